// File: doc/BRIEF.md
# Overrange Flag and Auto-Reset Controller

This block watches one converter channel and turns three per-cycle conditions into a single registered status flag. The conditions are: the input is beyond full scale, the loop filter is saturated, and an internal memory operation is busy. It also decides when the modulator must be reset automatically. In that case it drives a reset pulse of fixed length, then waits for the modulator to report that the reset is done.

Two configuration inputs select how the flag behaves. The first is an enable for automatic reset. The second is a two-bit indicator mode, which picks between two meanings of the flag:

- **Overrange meaning:** the flag is high when the input is out of range.
- **Data-valid meaning:** the flag is low while memory is busy.

An automatic reset starts in either of two ways. The first is an uninterrupted run of overrange cycles. The second is saturation, which starts a reset at once. The reset interval is folded into the flag in both meanings, so a downstream gain loop or capture logic sees the disturbance.

Top module: `ovr_reset_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `or_flag_o` and `mod_rst_o` are 0.
- R2: Overrange meaning is selected when `ind_mode_i` is anything other than 2'b11. With no reset in progress, `or_flag_o` equals the `ovr_i` value sampled at the previous rising clock edge.
- R3: Data-valid meaning is selected when `ind_mode_i` is 2'b11. With no reset in progress, `or_flag_o` is the inverse of the `mem_busy_i` value sampled at the previous edge, and `ovr_i` has no effect on it.
- R4: With `auto_rst_en_i` high, `mod_rst_o` goes high one clock after the 16th consecutive cycle in which `ovr_i` is sampled high. After only 15 such cycles it stays low.
- R5: A single cycle with `ovr_i` low restarts the run count, so two runs of 10 high cycles separated by one low cycle start no reset.
- R6: With `auto_rst_en_i` high and no reset in progress, one cycle with `sat_i` high makes `mod_rst_o` high one clock later, whatever the state of `ovr_i`.
- R7: `mod_rst_o` stays high for exactly RST_LEN cycles (default 8). After that, the reset remains in progress, with `mod_rst_o` low, until `rst_done_i` is sampled high.
- R8: While a reset is in progress, the flag is held in its asserted state: 1 in overrange meaning, 0 in data-valid meaning. This holds whatever the values of `ovr_i` and `mem_busy_i`.
- R9: The run count is zero throughout a reset and during the one cycle after `rst_done_i` is accepted. An `ovr_i` high in that cycle does not count, so a new reset needs 16 further high cycles.
- R10: Driving `auto_rst_en_i` low during a reset does not shorten it. The pulse and the wait for `rst_done_i` complete as usual.
- R11: With `auto_rst_en_i` low, neither saturation nor any length of overrange starts a reset. The run count saturates at 16, so raising the enable while `ovr_i` is still high after a long run starts a reset after a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovr_i | input | 1 | Per-cycle overrange indication |
| sat_i | input | 1 | Loop-filter saturation indication |
| mem_busy_i | input | 1 | Calibration or memory transfer in progress |
| auto_rst_en_i | input | 1 | Automatic modulator reset enable |
| ind_mode_i | input | 2 | Flag meaning: 2'b11 data-valid, other values overrange |
| rst_done_i | input | 1 | Modulator reports its reset finished |
| or_flag_o | output | 1 | Registered status flag |
| mod_rst_o | output | 1 | Modulator reset pulse |

## Verification
Two pairs of functions can coincide in one cycle.

- **Saturation and the 16th overrange cycle.** Saturation can arrive on the very cycle that completes a 16-cycle run. The bench provokes this by random bursts of overrange with rare saturation, and judges that a single pulse of RST_LEN cycles results, not two.
- **Data-valid mapping and a reset.** In data-valid meaning, a memory-busy cycle can overlap a reset. Both pull the flag low, and the bench checks that the flag rises only once both have cleared.

A cycle-accurate reference model in the bench judges every cycle of both directed and random traffic.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_COOL  = 2'd3
    } rst_state_e;

    typedef struct packed {
        rst_state_e state;     // current reset sequencer state
        logic       busy_nxt;  // reset in progress after this edge
        logic       clr;       // clear run counter this cycle
    } rst_status_s;

    localparam logic [1:0] MODE_DATA_VALID = 2'b11;

    function automatic logic is_data_valid(input logic [1:0] mode);
        return mode == MODE_DATA_VALID;
    endfunction

    function automatic logic flag_value(input logic dv, input logic ovr,
                                        input logic mem, input logic busy);
        return dv ? !(mem | busy) : (ovr | busy);
    endfunction

endpackage

// File: rtl/ovr_run_counter.sv
module ovr_run_counter
    import ovr_pkg::*;
#(
    parameter int RUN_LEN = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             ovr_i,
    input  logic                             clr_i,
    output logic [$clog2(RUN_LEN+1)-1:0]     cnt_o,
    output logic                             run_hit_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN);
    localparam logic [CW-1:0] HIT_AT  = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i || !ovr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign run_hit_o = ovr_i && (cnt_q >= HIT_AT);
    assign cnt_o     = cnt_q;

    a_r5_low_clears: assert property (@(posedge clk) disable iff (rst)
        !ovr_i |=> cnt_q == '0);
    a_r11_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

endmodule

// File: rtl/ovr_rst_seq.sv
module ovr_rst_seq
    import ovr_pkg::*;
#(
    parameter int RST_LEN = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  logic        sat_i,
    input  logic        run_hit_i,
    input  logic        done_i,
    output rst_status_s status_o,
    output logic        mod_rst_o
);
    localparam int PW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
    localparam logic [PW-1:0] PLAST = PW'(RST_LEN - 1);

    rst_state_e    state_q, state_d;
    logic [PW-1:0] pcnt_q, pcnt_d;
    logic          start_c;

    assign start_c = (state_q == ST_IDLE) && en_i && (sat_i || run_hit_i);

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_c) begin
                    state_d = ST_PULSE;
                    pcnt_d  = '0;
                end
            end
            ST_PULSE: begin
                if (pcnt_q == PLAST) begin
                    state_d = ST_WAIT;
                end else begin
                    pcnt_d = pcnt_q + PW'(1);
                end
            end
            ST_WAIT: begin
                if (done_i) state_d = ST_COOL;
            end
            ST_COOL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    assign status_o.state    = state_q;
    assign status_o.busy_nxt = (state_d == ST_PULSE) || (state_d == ST_WAIT);
    assign status_o.clr      = start_c || (state_q != ST_IDLE);
    assign mod_rst_o         = (state_q == ST_PULSE);

    a_r6_sat_starts: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && en_i && sat_i) |=> state_q == ST_PULSE);
    a_r11_disabled_no_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !en_i) |=> state_q != ST_PULSE);
    a_r7_wait_for_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !done_i) |=> state_q == ST_WAIT);
    a_r10_pulse_runs_on: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_PULSE |=> (state_q == ST_PULSE || state_q == ST_WAIT));
    a_r7_pulse_index: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_PULSE |-> pcnt_q <= PLAST);

endmodule

// File: rtl/ovr_flag_gen.sv
module ovr_flag_gen
    import ovr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       ovr_i,
    input  logic       mem_i,
    input  logic       busy_nxt_i,
    output logic       flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_value(is_data_valid(mode_i), ovr_i, mem_i, busy_nxt_i);
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/ovr_reset_ctrl.sv
module ovr_reset_ctrl
    import ovr_pkg::*;
#(
    parameter int RUN_LEN = 16,
    parameter int RST_LEN = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ovr_i,
    input  logic       sat_i,
    input  logic       mem_busy_i,
    input  logic       auto_rst_en_i,
    input  logic [1:0] ind_mode_i,
    input  logic       rst_done_i,
    output logic       or_flag_o,
    output logic       mod_rst_o
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_cnt;
    logic          run_hit;
    rst_status_s   seq_st;

    ovr_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ovr_i     (ovr_i),
        .clr_i     (seq_st.clr),
        .cnt_o     (run_cnt),
        .run_hit_o (run_hit)
    );

    ovr_rst_seq #(.RST_LEN(RST_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en_i      (auto_rst_en_i),
        .sat_i     (sat_i),
        .run_hit_i (run_hit),
        .done_i    (rst_done_i),
        .status_o  (seq_st),
        .mod_rst_o (mod_rst_o)
    );

    ovr_flag_gen u_flag (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (ind_mode_i),
        .ovr_i      (ovr_i),
        .mem_i      (mem_busy_i),
        .busy_nxt_i (seq_st.busy_nxt),
        .flag_o     (or_flag_o)
    );

    a_r9_cnt_zero_in_reset: assert property (@(posedge clk) disable iff (rst)
        (seq_st.state != ST_IDLE) |-> run_cnt == '0);
    a_r8_flag_high_normal: assert property (@(posedge clk) disable iff (rst)
        (mod_rst_o && $past(ind_mode_i) != MODE_DATA_VALID) |-> or_flag_o);
    a_r8_flag_low_valid: assert property (@(posedge clk) disable iff (rst)
        (mod_rst_o && $past(ind_mode_i) == MODE_DATA_VALID) |-> !or_flag_o);

endmodule

// File: tb/test_ovr_reset_ctrl.sv
module test_ovr_reset_ctrl;

    localparam int RUN_LEN = 16;
    localparam int RST_LEN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b_ovr = 0, b_sat = 0, b_mem = 0, b_en = 0, b_done = 0;
    logic [1:0] b_mode = 2'b00;
    logic or_flag, mod_rst;

    int checks = 0;
    int fails  = 0;

    // reference model state: 0 idle, 1 pulse, 2 wait, 3 cool
    int   m_state = 0;
    int   m_pc = 0;
    int   m_cnt = 0;
    logic m_flag = 0;
    logic m_rst = 0;

    always #4 clk = ~clk;

    ovr_reset_ctrl #(.RUN_LEN(RUN_LEN), .RST_LEN(RST_LEN)) i_ovr_reset_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ovr_i         (b_ovr),
        .sat_i         (b_sat),
        .mem_busy_i    (b_mem),
        .auto_rst_en_i (b_en),
        .ind_mode_i    (b_mode),
        .rst_done_i    (b_done),
        .or_flag_o     (or_flag),
        .mod_rst_o     (mod_rst)
    );

    function automatic logic exp_flag(logic [1:0] md, logic o, logic m, logic busy);
        if (md == 2'b11) return !(m || busy);
        return o || busy;
    endfunction

    task automatic model_update();
        int  ns;
        logic start;
        if (rst) begin
            m_state = 0; m_pc = 0; m_cnt = 0; m_flag = 0; m_rst = 0;
            return;
        end
        start = (m_state == 0) && b_en && (b_sat || (b_ovr && m_cnt >= RUN_LEN - 1));
        ns = m_state;
        case (m_state)
            0: if (start) begin ns = 1; m_pc = 0; end
            1: if (m_pc == RST_LEN - 1) ns = 2; else m_pc = m_pc + 1;
            2: if (b_done) ns = 3;
            default: ns = 0;
        endcase
        if (start || m_state != 0 || !b_ovr) m_cnt = 0;
        else if (m_cnt < RUN_LEN) m_cnt = m_cnt + 1;
        m_flag  = exp_flag(b_mode, b_ovr, b_mem, (ns == 1) || (ns == 2));
        m_rst   = (ns == 1);
        m_state = ns;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: inputs already driven at negedge, model at posedge, compare at negedge
    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R2/R3/R8 flag vs model", or_flag, m_flag);
        chk("R4/R6/R7 reset vs model", mod_rst, m_rst);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_reset();
        b_ovr = 0; b_sat = 0; b_done = 1;
        for (int i = 0; i < 40 && m_state != 0; i++) tick();
        b_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst = 1; ticks(3);
        chk("R1 flag in reset", or_flag, 1'b0);
        chk("R1 mod_rst in reset", mod_rst, 1'b0);
        rst = 0; tick();
        chk("R1 flag after reset", or_flag, 1'b0);
        chk("R1 mod_rst after reset", mod_rst, 1'b0);

        // R2 overrange meaning
        b_mode = 2'b00; b_en = 0; b_ovr = 1; tick();
        chk("R2 flag follows ovr high", or_flag, 1'b1);
        b_ovr = 0; b_mem = 1; tick();
        chk("R2 flag follows ovr low", or_flag, 1'b0);

        // R3 data-valid meaning
        b_mode = 2'b11; b_mem = 1; b_ovr = 1; tick();
        chk("R3 flag low while mem busy", or_flag, 1'b0);
        b_mem = 0; tick();
        chk("R3 flag high, ovr ignored", or_flag, 1'b1);

        // other mode codes behave as overrange meaning
        b_mode = 2'b01; b_ovr = 1; b_mem = 1; tick();
        chk("R2 mode 01 overrange meaning", or_flag, 1'b1);
        b_ovr = 0; b_mem = 0; tick();
        chk("R2 mode 01 no data-valid meaning", or_flag, 1'b0);

        // R4 run length
        b_mode = 2'b00; b_en = 1; b_ovr = 1; ticks(15);
        chk("R4 no reset after 15 high", mod_rst, 1'b0);
        b_ovr = 0; tick();
        chk("R4 short run ends quietly", mod_rst, 1'b0);
        // R5 one low cycle clears
        b_ovr = 1; ticks(10); b_ovr = 0; tick(); b_ovr = 1; ticks(10);
        chk("R5 split run no reset", mod_rst, 1'b0);
        b_ovr = 0; tick();
        b_ovr = 1; ticks(16);
        chk("R4 reset after 16 high", mod_rst, 1'b1);
        chk("R8 flag asserted on reset", or_flag, 1'b1);
        // R7 pulse length then wait
        b_ovr = 0; ticks(RST_LEN - 1);
        chk("R7 pulse still high at last cycle", mod_rst, 1'b1);
        tick();
        chk("R7 pulse ends after RST_LEN", mod_rst, 1'b0);
        chk("R8 flag held while awaiting done", or_flag, 1'b1);
        ticks(3);
        chk("R7 still awaiting done", or_flag, 1'b1);
        b_done = 1; tick(); b_done = 0;
        chk("R7 done releases flag", or_flag, 1'b0);
        // R9 cool-down cycle ignores ovr
        b_ovr = 1; tick(); ticks(15);
        chk("R9 cool cycle not counted", mod_rst, 1'b0);
        tick();
        chk("R9 reset after 16 fresh high", mod_rst, 1'b1);
        finish_reset();

        // R6 saturation
        b_ovr = 0; b_sat = 1; tick(); b_sat = 0;
        chk("R6 saturation starts reset", mod_rst, 1'b1);
        finish_reset();

        // R8 data-valid during reset
        b_mode = 2'b11; b_mem = 0; b_sat = 1; tick(); b_sat = 0;
        chk("R8 data-valid flag low in reset", or_flag, 1'b0);
        chk("R6 reset in data-valid meaning", mod_rst, 1'b1);
        finish_reset();
        tick();
        chk("R8 data-valid flag back high", or_flag, 1'b1);

        // R10 disable mid reset
        b_mode = 2'b00; b_sat = 1; tick(); b_sat = 0; b_en = 0;
        ticks(RST_LEN - 1);
        chk("R10 pulse continues when disabled", mod_rst, 1'b1);
        tick();
        chk("R10 still in progress when disabled", or_flag, 1'b1);
        b_done = 1; tick(); b_done = 0;
        chk("R10 completes on done", or_flag, 1'b0);

        // R11 disabled never starts, counter saturates
        b_sat = 1; tick(); b_sat = 0;
        chk("R11 saturation ignored when disabled", mod_rst, 1'b0);
        b_ovr = 1; ticks(20);
        chk("R11 long run ignored when disabled", mod_rst, 1'b0);
        b_en = 1; tick();
        chk("R11 saturated count fires on enable", mod_rst, 1'b1);
        finish_reset();

        // random phase against the model
        begin
            int pct = 50;
            for (int c = 0; c < 4000; c++) begin
                if (c % 64 == 0) begin
                    case ($urandom % 4)
                        0: pct = 5;
                        1: pct = 50;
                        2: pct = 97;
                        default: pct = 100;
                    endcase
                end
                if (c % 256 == 0) begin
                    case ($urandom % 3)
                        0: b_mode = 2'b00;
                        1: b_mode = 2'b11;
                        default: b_mode = 2'b10;
                    endcase
                end
                if (c % 128 == 0) b_en = ($urandom % 10) != 0;
                b_ovr  = ($urandom % 100) < pct;
                b_sat  = ($urandom % 150) == 0;
                b_mem  = ($urandom % 5) == 0;
                b_done = ($urandom % 3) == 0;
                tick();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule